// File: doc/BRIEF.md
# Phase-Rotating Fractional Clock Divider

This block is a cycle-accurate digital model of an open-loop core-clock synthesizer. Its input is an oscillator that offers eight equally spaced phases. The model runs on a tick clock whose period is one eighth of the oscillator period. A one-hot rotator picks the active phase. Each time the rotator moves back by one or two phases, the multiplexed clock loses one or two ticks from its nominal eight-tick period. The multiplexed clock then goes through a divide-by-2-or-3 stage, which also issues the rotator's advance enables. After that, an even synchronous divider produces an output clock with an exact 50% duty cycle.

A 6-bit frequency word selects the rotation step, the 2/3 ratio and the output ratio. The word is taken only at the rising edge of each output cycle and then held for that whole cycle. Software can therefore change the frequency for any output cycle without producing a glitch. A debug output reports the length, in ticks, of the most recently completed output cycle.

Top module: `phase_rot_div`

## Requirements
- R1: While reset is high, and on the first tick after it, `clk_o` is high, `phase_sel_o` is 8'h01 and `period_o` is 0.
- R2: `phase_sel_o` always has exactly one bit set.
- R3: The rotator only moves toward lower indices, with bit i moving to bit (i - step) mod 8. It moves once per multiplexed cycle, in the first N23-1 multiplexed cycles of each intermediate cycle. Over one output cycle the select therefore rotates by step*D*(N23-1) positions. With step 0 it never moves.
- R4: Word encoding. Bits [1:0] give the step (0, 1 or 2 phases). Bit 2 selects N23=3 when set and N23=2 when clear. Bits [5:3], read as k, give the output ratio D=2(k+1).
- R5: Each output period lasts exactly D*(8*N23 - step*(N23-1)) ticks.
- R6: Each output cycle is high for exactly half of its ticks, and the high part comes first.
- R7: The word is sampled on the tick edge where the output rises, and it governs the cycle that starts there. Changes between two rising edges, including several changes, have no effect on the cycle that is running.
- R8: A step field of 3 selects the slowest setting, whatever the other bits are: step 0, N23=3, D=16, which gives 384 ticks.
- R9: `period_o` updates at each rising edge of `clk_o` to the tick length of the cycle that just ended.
- R10: `clk_o` changes only at the end of an intermediate (divide-by-2/3) cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one eighth of the oscillator period |
| rst | input | 1 | Synchronous active-high reset |
| fcw_i | input | 6 | Frequency control word |
| clk_o | output | 1 | Synthesized core clock |
| phase_sel_o | output | 8 | One-hot phase select from the rotator |
| period_o | output | 10 | Tick length of the last completed output cycle |

## Verification
The embedded assertions check the per-cycle structural properties. These are the one-hot select, a rotator that stays still when no enable is present and always moves when one is, settings that always decode to a legal even ratio, an output that toggles only at intermediate boundaries and is low at a cycle's final tick, and a multiplexed-cycle index that stays in range. Only the bench's scenarios show the arithmetic results. These are the exact period for each word, the exact half-high duty, the cumulative rotation per output cycle, the value reported on the debug output, and the rule that mid-cycle word changes wait for the next rising edge.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
    localparam int PHASES  = 8;
    localparam int FCW_W   = 6;
    localparam int STEP_W  = 2;
    localparam int RATIO_W = 5;
    localparam int TICK_W  = $clog2(PHASES);

    typedef struct packed {
        logic [STEP_W-1:0]  step;   // phases dropped per switch
        logic               three;  // 1: divide by 3, 0: divide by 2
        logic [RATIO_W-1:0] ratio;  // even output ratio
    } div_cfg_t;

    localparam div_cfg_t SLOWEST_CFG = '{step: 2'd0, three: 1'b1, ratio: 5'd16};

    function automatic div_cfg_t decode_fcw(input logic [FCW_W-1:0] w);
        div_cfg_t c;
        if (w[1:0] == 2'd3) begin
            c = SLOWEST_CFG;
        end else begin
            c.step  = w[1:0];
            c.three = w[2];
            c.ratio = {1'b0, w[5:3], 1'b0} + 5'd2;
        end
        return c;
    endfunction
endpackage

// File: rtl/pdiv_ctrl.sv
module pdiv_ctrl
    import pdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [FCW_W-1:0] fcw,
    input  logic             load,
    output div_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg <= decode_fcw(fcw);
        end
    end

    // R4 R8: held settings are always legal
    p_legal_cfg_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.ratio[0] == 1'b0) && (cfg.ratio >= 5'd2) && (cfg.ratio <= 5'd16) && (cfg.step != 2'd3));
endmodule

// File: rtl/pdiv_prescale.sv
module pdiv_prescale
    import pdiv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  div_cfg_t cfg,
    output logic     rot_en,
    output logic     c23_end
);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(PHASES - 1);

    logic [TICK_W-1:0] tick_q;
    logic [1:0]        cm_q;
    logic [1:0]        cm_last;
    logic              sw_now;
    logic [TICK_W-1:0] cm_stop;
    logic              cm_end;

    assign cm_last = cfg.three ? 2'd2 : 2'd1;
    assign sw_now  = (cfg.step != 2'd0) && (cm_q != cm_last);
    assign cm_stop = sw_now ? (LAST_TICK - TICK_W'(cfg.step)) : LAST_TICK;
    assign cm_end  = (tick_q == cm_stop);
    assign rot_en  = cm_end && sw_now;
    assign c23_end = cm_end && (cm_q == cm_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            tick_q <= '0;
            cm_q   <= '0;
        end else if (cm_end) begin
            tick_q <= '0;
            cm_q   <= c23_end ? 2'd0 : cm_q + 2'd1;
        end else begin
            tick_q <= tick_q + TICK_W'(1);
        end
    end

    // R5: multiplexed-cycle index stays inside the selected 2/3 ratio
    p_cm_range_r5: assert property (@(posedge clk) disable iff (rst)
        cm_q <= cm_last);
endmodule

// File: rtl/pdiv_rotator.sv
module pdiv_rotator
    import pdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rot_en,
    input  logic [STEP_W-1:0] step,
    output logic [PHASES-1:0] sel
);
    logic [PHASES-1:0] nxt;

    for (genvar i = 0; i < PHASES; i++) begin : g_rot
        assign nxt[i] = (step == 2'd2) ? sel[(i + 2) % PHASES] : sel[(i + 1) % PHASES];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel <= PHASES'(1);
        end else if (rot_en) begin
            sel <= nxt;
        end
    end

    // R2: exactly one phase selected
    p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
        $countones(sel) == 1);
    // R3: no enable, no movement
    p_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !rot_en |=> $stable(sel));
    // R3: an enable always moves the select
    p_moves_r3: assert property (@(posedge clk) disable iff (rst)
        rot_en |=> (sel != $past(sel)));
endmodule

// File: rtl/pdiv_outdiv.sv
module pdiv_outdiv
    import pdiv_pkg::*;
#(
    parameter int PER_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             c23_end,
    input  div_cfg_t         cfg,
    output logic             clk_o,
    output logic             boundary,
    output logic [PER_W-1:0] period_o
);
    logic [RATIO_W-1:0] c23_q;
    logic [RATIO_W-1:0] half;
    logic [PER_W-1:0]   cnt_q;

    assign half     = cfg.ratio >> 1;
    assign clk_o    = (c23_q < half);
    assign boundary = c23_end && (c23_q == (cfg.ratio - RATIO_W'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            c23_q    <= '0;
            cnt_q    <= '0;
            period_o <= '0;
        end else begin
            if (c23_end) begin
                c23_q <= boundary ? '0 : c23_q + RATIO_W'(1);
            end
            if (boundary) begin
                cnt_q    <= '0;
                period_o <= cnt_q + PER_W'(1);
            end else begin
                cnt_q <= cnt_q + PER_W'(1);
            end
        end
    end

    // R10: output toggles only at an intermediate boundary
    p_clk_steady_r10: assert property (@(posedge clk) disable iff (rst)
        !c23_end |=> $stable(clk_o));
    // R6: the last tick of a cycle is in the low half
    p_low_at_end_r6: assert property (@(posedge clk) disable iff (rst)
        boundary |-> !clk_o);
endmodule

// File: rtl/phase_rot_div.sv
module phase_rot_div
    import pdiv_pkg::*;
#(
    parameter int PER_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FCW_W-1:0]  fcw_i,
    output logic              clk_o,
    output logic [PHASES-1:0] phase_sel_o,
    output logic [PER_W-1:0]  period_o
);
    div_cfg_t cfg;
    logic     rot_en;
    logic     c23_end;
    logic     boundary;

    pdiv_ctrl u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .fcw  (fcw_i),
        .load (boundary),
        .cfg  (cfg)
    );

    pdiv_prescale u_pre (
        .clk     (clk),
        .rst     (rst),
        .cfg     (cfg),
        .rot_en  (rot_en),
        .c23_end (c23_end)
    );

    pdiv_rotator u_rot (
        .clk    (clk),
        .rst    (rst),
        .rot_en (rot_en),
        .step   (cfg.step),
        .sel    (phase_sel_o)
    );

    pdiv_outdiv #(.PER_W(PER_W)) u_out (
        .clk      (clk),
        .rst      (rst),
        .c23_end  (c23_end),
        .cfg      (cfg),
        .clk_o    (clk_o),
        .boundary (boundary),
        .period_o (period_o)
    );
endmodule

// File: tb/phase_rot_div_test.sv
`timescale 1ns/1ps
module phase_rot_div_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] fcw = 6'd0;
    logic       clk_o;
    logic [7:0] phase_sel_o;
    logic [9:0] period_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    phase_rot_div uut (
        .clk         (clk),
        .rst         (rst),
        .fcw_i       (fcw),
        .clk_o       (clk_o),
        .phase_sel_o (phase_sel_o),
        .period_o    (period_o)
    );

    // Bench model of the word encoding (R4, R8)
    function automatic void model(input logic [5:0] w, output int s, output int n, output int d);
        if (w[1:0] == 2'd3) begin
            s = 0; n = 3; d = 16;
        end else begin
            s = int'(w[1:0]);
            n = w[2] ? 3 : 2;
            d = 2 * (int'(w[5:3]) + 1);
        end
    endfunction

    function automatic int exp_period(input logic [5:0] w);
        int s, n, d;
        model(w, s, n, d);
        return d * (8 * n - s * (n - 1));
    endfunction

    function automatic int exp_shift(input logic [5:0] w);
        int s, n, d;
        model(w, s, n, d);
        return s * d * (n - 1);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    localparam int DIRECTED  = 8;
    localparam int RANDOMS   = 110;
    localparam int TICK_LIMIT = 150000;

    logic [5:0] dir_words [DIRECTED];

    initial begin
        int   total, per, hi, exp_pos, done, change_at, change2_at;
        logic prev, started, dbl;
        logic [5:0] start_word;
        string tag;
        void'($urandom(32'd4242));
        dir_words[0] = 6'b000_0_00;  // R4: step 0, /2, D=2  -> 32
        dir_words[1] = 6'b111_1_10;  // R4: step 2, /3, D=16 -> 320
        dir_words[2] = 6'b000_1_10;  // R4: step 2, /3, D=2  -> 40
        dir_words[3] = 6'b000_0_10;  // R4: step 2, /2, D=2  -> 28
        dir_words[4] = 6'b101_0_11;  // R8: illegal step -> 384
        dir_words[5] = 6'b000_1_01;  // R4: step 1, /3, D=2  -> 44
        dir_words[6] = 6'b011_0_01;  // R4: step 1, /2, D=8  -> 120
        dir_words[7] = 6'b000_1_11;  // R8: illegal step -> 384

        fcw = 6'b010_1_01;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 clk_o", int'(clk_o), 1);
        chk("R1 phase_sel_o", int'(phase_sel_o), 1);
        chk("R1 period_o", int'(period_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 phase_sel_o after release", int'(phase_sel_o), 1);
        chk("R1 period_o after release", int'(period_o), 0);

        prev = clk_o; started = 1'b0; done = 0; total = 0;
        per = 0; hi = 0; exp_pos = 0; change_at = -1; change2_at = -1;
        start_word = fcw; dbl = 1'b0; tag = "R5";

        while (done < DIRECTED + RANDOMS && total < TICK_LIMIT) begin
            @(negedge clk);
            total++;
            if (clk_o && !prev) begin
                if (started) begin
                    chk({tag, " period"}, per, exp_period(start_word));
                    chk("R6 high half", 2 * hi, per);
                    chk("R9 period_o", int'(period_o), per);
                    exp_pos = ((exp_pos - exp_shift(start_word)) % 8 + 8) % 8;
                    chk("R3 phase_sel_o", int'(phase_sel_o), 1 << exp_pos);
                    chk("R2 onehot", $countones(phase_sel_o), 1);
                    done++;
                end else begin
                    for (int i = 0; i < 8; i++) if (phase_sel_o[i]) exp_pos = i;
                    started = 1'b1;
                end
                start_word = fcw;  // value present at the capture edge (R7)
                tag = (start_word[1:0] == 2'd3) ? "R8" : (done < DIRECTED ? "R4" : (dbl ? "R7" : "R5"));
                per = 0; hi = 0;
                change_at  = 1 + int'($urandom % 20);
                dbl        = ($urandom % 3) == 0;
                change2_at = dbl ? change_at + 3 : -1;
            end
            if (clk_o) hi++;
            per++;
            prev = clk_o;
            if (per == change_at || per == change2_at) begin
                if (done < DIRECTED - 1 && per == change_at) fcw = dir_words[done + 1];
                else fcw = 6'($urandom);
            end
        end

        if (total >= TICK_LIMIT) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected<%0d", total, TICK_LIMIT);
        end
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule